// File: doc/BRIEF.md
# Minifloat Add/Subtract Unit

This block adds or subtracts two floating-point operands held in a compact 12-bit word. Bit 11 is the sign. Bits 10..6 are a 5-bit exponent stored with a bias of 15. Bits 5..0 are the fraction of a significand whose leading 1 is implied. Exponent code 0 means zero, and in that case the fraction bits are ignored. Exponent code 31 means infinity. Codes 1 to 30 are normal values.

The datapath works in five steps:
1. It compares the exponents.
2. It swaps the operands so that the larger magnitude is on one fixed side.
3. It shifts the smaller significand right to align it.
4. It adds or subtracts the significands.
5. It normalises the result with a leading-zero count.

The sign of each operand and the operation bit together decide whether the significands are added or subtracted. They also set the sign of the result. Bits shifted out are dropped. There are no guard bits and no rounding.

The result is computed combinationally and captured in one output register. It appears on the clock edge after the operands are presented. A surrounding datapath drives both operands and the operation bit every cycle and reads the result one cycle later.

Top module: `mf_addsub_top`

## Requirements
- R1: `res_o` is cleared to 0x000 while `rst_n` is low, and this clear is asynchronous. After reset, `res_o` shows the result for the operands sampled at the previous rising clock edge. It does not change before that edge.
- R2: When the effective operation is an add, the significand with the smaller exponent is shifted right by the exponent difference, and shifted-out bits are dropped. It is then added to the other significand. The result takes the larger exponent (example: 0x3C0 + 0x37F = 0x3DF).
- R3: If the significand sum carries out, it is shifted right by one, dropping a bit, and the exponent is incremented. If the exponent reaches 31, the result is infinity: exponent 11111, fraction 000000, and the sign of the result.
- R4: The significands are subtracted when the operation bit (`sub_i`, 1 = subtract) XOR sign A XOR sign B is 1. Otherwise they are added. For example, a negative A minus a positive B is an add with a negative result.
- R5: On a subtract, the result sign is the effective sign of the operand with the larger exponent. When the exponents are equal, it is the effective sign of the operand with the larger significand. The effective sign of B is its sign XOR `sub_i`.
- R6: A result with leading zeros is shifted left by the leading-zero count. The count is taken off the larger exponent, and the fraction is truncated to 6 bits.
- R7: A subtraction whose result is exactly zero gives +0 (0x000).
- R8: If normalisation would bring the exponent below 1, the result is flushed to 0x000. An exponent of exactly 1 is kept.
- R9: If the exponent difference is greater than 7, the result is the operand with the larger exponent, unchanged, with its effective sign.
- R10: A zero operand (exponent 00000, any fraction) lets the other operand through. B is passed with its sign flipped when `sub_i` is 1. If both operands are zero, the result is 0x000.
- R11: If either operand has exponent 11111, the result is infinity with fraction 000000. The sign is A's sign if A is infinite, and otherwise B's effective sign. This includes infinity minus infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 12 | Operand A: sign, biased exponent, fraction |
| opb_i | input | 12 | Operand B, same layout |
| sub_i | input | 1 | 0 = A + B, 1 = A - B |
| res_o | output | 12 | Registered result |

## Verification
The bench builds the unit with its default widths: a 5-bit exponent and a 6-bit fraction. With these widths, an 11-bit magnitude can be chosen by hand for every corner:
- Overflow into code 31 comes from adding two operands with exponent 30.
- The flush boundary sits between results whose exponent would be 0 and 1.
- Alignment distances of 6, 7 and 8 straddle the bypass threshold.

Each vector's expected word is worked out from the requirement's arithmetic. This covers truncation on alignment, both sign-selection rules on subtract, and the precedence of infinity over zero.

// File: rtl/mf_pkg.sv
package mf_pkg;

  // Kind of operation applied to the aligned significands.
  typedef enum logic {
    SIG_ADD = 1'b0,
    SIG_SUB = 1'b1
  } sig_op_e;

  // Operand class, derived from the exponent field.
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2
  } op_class_e;

endpackage

// File: rtl/mf_align.sv
module mf_align #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 6
) (
  input  logic [EXP_W+FRAC_W:0] opa_i,
  input  logic [EXP_W+FRAC_W:0] opb_i,
  input  logic                  sub_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_big_o,
  output logic [FRAC_W:0]       sig_big_o,
  output logic [FRAC_W:0]       sig_small_o,
  output mf_pkg::sig_op_e       op_o,
  output logic                  far_o
);
  localparam int SW = FRAC_W + 1;
  localparam int W  = EXP_W + FRAC_W + 1;

  logic              sa, sb_eff, a_big;
  logic [EXP_W-1:0]  ea, eb, shamt;
  logic [FRAC_W-1:0] fa, fb;
  logic [SW-1:0]     small_raw;

  always_comb begin
    sa     = opa_i[W-1];
    sb_eff = opb_i[W-1] ^ sub_i;
    ea     = opa_i[W-2:FRAC_W];
    eb     = opb_i[W-2:FRAC_W];
    fa     = opa_i[FRAC_W-1:0];
    fb     = opb_i[FRAC_W-1:0];
    // Swap so that the larger magnitude is always on the "big" side.
    a_big  = (ea > eb) || ((ea == eb) && (fa >= fb));
    if (a_big) begin
      exp_big_o = ea;
      sig_big_o = {1'b1, fa};
      small_raw = {1'b1, fb};
      shamt     = ea - eb;
      sign_o    = sa;
    end else begin
      exp_big_o = eb;
      sig_big_o = {1'b1, fb};
      small_raw = {1'b1, fa};
      shamt     = eb - ea;
      sign_o    = sb_eff;
    end
    sig_small_o = small_raw >> shamt;
    far_o       = (shamt > EXP_W'(SW));
    op_o        = (sa ^ sb_eff) ? mf_pkg::SIG_SUB : mf_pkg::SIG_ADD;
  end

endmodule

// File: rtl/mf_sigop.sv
module mf_sigop #(
  parameter int SW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   sig_big_i,
  input  logic [SW-1:0]   sig_small_i,
  input  mf_pkg::sig_op_e op_i,
  output logic [SW:0]     sum_o
);

  always_comb begin
    if (op_i == mf_pkg::SIG_SUB) begin
      sum_o = {1'b0, sig_big_i} - {1'b0, sig_small_i};
    end else begin
      sum_o = {1'b0, sig_big_i} + {1'b0, sig_small_i};
    end
  end

  // The swap must leave the big side no smaller, so a subtract never borrows.
  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == mf_pkg::SIG_SUB) |-> (sum_o[SW] == 1'b0)); // R5

endmodule

// File: rtl/mf_norm.sv
module mf_norm #(
  parameter int EXP_W = 5,
  parameter int SW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW:0]       sum_i,
  input  logic [EXP_W-1:0]  exp_big_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SW-2:0]     frac_o,
  output logic              zero_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam logic [EXP_W-1:0] EMAX = {EXP_W{1'b1}};

  logic             carry, found;
  logic [EXP_W-1:0] lz;
  logic [SW-1:0]    sig_n;

  // Count leading zeros below the carry position.
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (!found) begin
        if (sum_i[i]) found = 1'b1;
        else          lz    = lz + EXP_W'(1);
      end
    end
  end

  always_comb begin
    carry  = sum_i[SW];
    zero_o = (sum_i == '0);
    if (carry) begin
      sig_n = sum_i[SW:1];
      exp_o = exp_big_i + EXP_W'(1);
      ovf_o = (exp_big_i == EMAX - EXP_W'(1));
      unf_o = 1'b0;
    end else begin
      sig_n = sum_i[SW-1:0] << lz;
      exp_o = exp_big_i - lz;
      ovf_o = 1'b0;
      unf_o = !zero_o && (lz >= exp_big_i);
    end
    frac_o = sig_n[SW-2:0];
  end

  // A nonzero, non-carry result must come out with its hidden bit set.
  AST_NORM_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_o && !carry) |-> sig_n[SW-1]); // R6

endmodule

// File: rtl/mf_addsub_top.sv
module mf_addsub_top #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EXP_W+FRAC_W:0] opa_i,
  input  logic [EXP_W+FRAC_W:0] opb_i,
  input  logic                  sub_i,
  output logic [EXP_W+FRAC_W:0] res_o
);
  import mf_pkg::*;

  localparam int W  = EXP_W + FRAC_W + 1;
  localparam int SW = FRAC_W + 1;
  localparam logic [EXP_W-1:0] EMAX = {EXP_W{1'b1}};

  logic             sign_big, far, n_zero, n_ovf, n_unf;
  logic [EXP_W-1:0] exp_big, exp_n;
  logic [SW-1:0]    sig_big, sig_small;
  logic [SW:0]      sum;
  logic [SW-2:0]    frac_n;
  sig_op_e          sig_op;
  op_class_e        cls_a, cls_b;
  logic [W-1:0]     res_d, res_q;

  mf_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) align_i (
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .sub_i       (sub_i),
    .sign_o      (sign_big),
    .exp_big_o   (exp_big),
    .sig_big_o   (sig_big),
    .sig_small_o (sig_small),
    .op_o        (sig_op),
    .far_o       (far)
  );

  mf_sigop #(.SW(SW)) sigop_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sig_big_i   (sig_big),
    .sig_small_i (sig_small),
    .op_i        (sig_op),
    .sum_o       (sum)
  );

  mf_norm #(.EXP_W(EXP_W), .SW(SW)) norm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sum_i     (sum),
    .exp_big_i (exp_big),
    .exp_o     (exp_n),
    .frac_o    (frac_n),
    .zero_o    (n_zero),
    .ovf_o     (n_ovf),
    .unf_o     (n_unf)
  );

  function automatic op_class_e classify(input logic [EXP_W-1:0] e);
    if (e == '0)        return CLS_ZERO;
    else if (e == EMAX) return CLS_INF;
    else                return CLS_NORM;
  endfunction

  // Next-state logic: special cases first, then the arithmetic path.
  always_comb begin
    cls_a = classify(opa_i[W-2:FRAC_W]);
    cls_b = classify(opb_i[W-2:FRAC_W]);
    if (cls_a == CLS_INF) begin
      res_d = {opa_i[W-1], EMAX, {FRAC_W{1'b0}}};
    end else if (cls_b == CLS_INF) begin
      res_d = {opb_i[W-1] ^ sub_i, EMAX, {FRAC_W{1'b0}}};
    end else if (cls_a == CLS_ZERO && cls_b == CLS_ZERO) begin
      res_d = '0;
    end else if (cls_a == CLS_ZERO) begin
      res_d = {opb_i[W-1] ^ sub_i, opb_i[W-2:0]};
    end else if (cls_b == CLS_ZERO) begin
      res_d = opa_i;
    end else if (far) begin
      res_d = {sign_big, exp_big, sig_big[FRAC_W-1:0]};
    end else if (n_zero || n_unf) begin
      res_d = '0;
    end else if (n_ovf) begin
      res_d = {sign_big, EMAX, {FRAC_W{1'b0}}};
    end else begin
      res_d = {sign_big, exp_n, frac_n};
    end
  end

  // Result register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign res_o = res_q;

  AST_INF_IN_GIVES_INF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(opa_i[W-2:FRAC_W]) == EMAX) |-> (res_q[W-2:0] == {EMAX, {FRAC_W{1'b0}}})); // R11
  AST_INF_CLEAN_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q[W-2:FRAC_W] == EMAX) |-> (res_q[FRAC_W-1:0] == '0)); // R3
  AST_ZERO_IS_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q[W-2:FRAC_W] == '0) |-> (res_q == '0)); // R7

endmodule

// File: tb/mf_addsub_top_tb_top.sv
`timescale 1ns/1ps
module mf_addsub_top_tb_top;
  localparam int NV = 31;

  logic        clk, rst_n, sub;
  logic [11:0] opa, opb, res;
  int          checks, errors;

  // {requirement tag, A, B, sub, expected}
  localparam logic [68:0] VEC [NV] = '{
    {"R2  ", 12'h3C0, 12'h380, 1'b0, 12'h3E0},
    {"R2  ", 12'h3C0, 12'h37F, 1'b0, 12'h3DF},
    {"R2  ", 12'h3C0, 12'h240, 1'b0, 12'h3C1},
    {"R3  ", 12'h3C0, 12'h3C0, 1'b0, 12'h400},
    {"R3  ", 12'h3E0, 12'h3F0, 1'b0, 12'h428},
    {"R3  ", 12'h780, 12'h780, 1'b0, 12'h7C0},
    {"R3  ", 12'hF80, 12'hF80, 1'b0, 12'hFC0},
    {"R4  ", 12'hBC0, 12'h380, 1'b1, 12'hBE0},
    {"R4  ", 12'h3C0, 12'hB80, 1'b0, 12'h380},
    {"R4  ", 12'hBC0, 12'hB80, 1'b1, 12'hB80},
    {"R5  ", 12'h380, 12'h3C0, 1'b1, 12'hB80},
    {"R5  ", 12'h3D0, 12'h3E0, 1'b1, 12'hB40},
    {"R5  ", 12'h3E0, 12'h3D0, 1'b1, 12'h340},
    {"R6  ", 12'h3C0, 12'h380, 1'b1, 12'h380},
    {"R6  ", 12'h3C0, 12'h240, 1'b1, 12'h3BE},
    {"R7  ", 12'h3E0, 12'h3E0, 1'b1, 12'h000},
    {"R7  ", 12'hBE0, 12'h3E0, 1'b0, 12'h000},
    {"R8  ", 12'h050, 12'h040, 1'b1, 12'h000},
    {"R8  ", 12'h0A0, 12'h080, 1'b1, 12'h040},
    {"R9  ", 12'h3C0, 12'h1C0, 1'b0, 12'h3C0},
    {"R9  ", 12'h3C0, 12'h1C0, 1'b1, 12'h3C0},
    {"R9  ", 12'h1C0, 12'h3C0, 1'b1, 12'hBC0},
    {"R9  ", 12'h3C0, 12'h200, 1'b1, 12'h3C0},
    {"R10 ", 12'h005, 12'h3E0, 1'b1, 12'hBE0},
    {"R10 ", 12'hBE0, 12'h00A, 1'b1, 12'hBE0},
    {"R10 ", 12'h800, 12'h000, 1'b0, 12'h000},
    {"R11 ", 12'h7C0, 12'h3C0, 1'b0, 12'h7C0},
    {"R11 ", 12'h3C0, 12'h7C0, 1'b1, 12'hFC0},
    {"R11 ", 12'h7C0, 12'h7C0, 1'b1, 12'h7C0},
    {"R11 ", 12'h7C3, 12'h3C0, 1'b0, 12'h7C0},
    {"R11 ", 12'h000, 12'hFC0, 1'b0, 12'hFC0}
  };

  mf_addsub_top dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .opa_i (opa),
    .opb_i (opb),
    .sub_i (sub),
    .res_o (res)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: res_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic [11:0] b, input logic s);
    opa = a; opb = b; sub = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    apply(12'h3C0, 12'h3C0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset", res, 12'h000);
    rst_n = 1'b1;

    // Vector table: drive at a falling edge, sample at the next falling edge.
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][36:25], VEC[i][24:13], VEC[i][12]);
      @(negedge clk);
      check(string'(VEC[i][68:37]), res, VEC[i][11:0]);
    end

    // R1: the output holds until the next rising edge, then updates.
    apply(12'h3C0, 12'h3C0, 1'b0);
    @(negedge clk);
    check("R1 settle", res, 12'h400);
    apply(12'h3C0, 12'h380, 1'b0);
    #1;
    check("R1 hold", res, 12'h400);
    @(negedge clk);
    check("R1 update", res, 12'h3E0);

    // R1: the reset clears the register without waiting for a clock edge.
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear", res, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;
    apply(12'hF80, 12'h780, 1'b1);
    @(negedge clk);
    check("R3 neg overflow via subtract", res, 12'hFC0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule